// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A purely combinational integer arithmetic-logic unit built from a parameterised row of identical one-bit slices. Each slice can invert either of its operand bits, adds them with a full adder, and drives its result bit from one of four sources: bitwise AND, bitwise OR, the adder sum, or a "less" input. A 4-bit operation code drives the invert controls and the source select. From these six operations come: AND, OR, add, subtract, signed set-less-than and NOR. No operation has a datapath of its own.

Subtraction forms a + ~b + 1. The invert-B control also drives the carry into slice 0. NOR is AND with both operands inverted. Set-less-than runs a subtraction and routes a sign bit, corrected for overflow, from the top slice back into the less input of slice 0. Every other slice sees a constant 0 on its less input. The carries ripple from slice to slice. Equality is tested by subtracting and reading the zero flag.

Top module: `slice_alu`

## Requirements
- R1: Code 4'b0010 (add) gives result = (a + b) mod 2^W, and cout is the carry out of bit W-1 of that sum.
- R2: Code 4'b0110 (subtract) gives result = (a - b) mod 2^W, and cout = 1 exactly when a >= b as unsigned numbers (no borrow).
- R3: For add and subtract, ovf is 1 exactly when the signed result does not fit in W bits. For every other code ovf is 0.
- R4: Code 4'b0000 gives a AND b. Code 4'b0001 gives a OR b.
- R5: Code 4'b1100 gives NOT (a OR b).
- R6: Code 4'b0111 (set-less-than) gives a result whose bit 0 is 1 exactly when a < b as two's-complement numbers, including when a - b overflows. Bits W-1..1 are 0. cout follows the rule of R2.
- R7: zero is 1 exactly when every result bit is 0, for every code. After a subtract, it is therefore 1 exactly when a equals b.
- R8: Every code not listed in R1, R2, R4, R5 and R6 behaves as AND, with ovf = 0 and cout = 0.
- R9: For AND, OR and NOR, cout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| ctrl_i | input | 4 | Operation code: bit 3 inverts A, bit 2 negates B, bits 1:0 select the source (00 AND, 01 OR, 10 sum, 11 less) |
| result_o | output | W | Selected result |
| zero_o | output | 1 | All result bits are 0 |
| ovf_o | output | 1 | Signed overflow for add and subtract |
| cout_o | output | 1 | Carry out of the top slice for add, subtract and set-less-than |

## Verification
The block holds no state, so a fault inside it shows at the ports in the same cycle as the operands that expose it. A broken link in the carry chain shows only on operands whose carries cross that link. The corner operands are therefore chosen to drive long carry runs: all ones plus one, and subtraction of equal values. A wrong feedback into slice 0 shows only when set-less-than meets a subtraction that overflows. It is probed with the most negative and most positive values against each other. A decode slip is caught by sweeping all sixteen codes against the same random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } op_e;

  typedef struct packed {
    logic inv_a;
    logic neg_b;
    sel_e sel;
    logic arith;  // add or subtract: flags meaningful
    logic slt;
  } ctl_t;

endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
  import alu_pkg::*;
(
  input  logic [3:0] code_i,
  output ctl_t       ctl_o
);

  always_comb begin
    ctl_o.inv_a = 1'b0;
    ctl_o.neg_b = 1'b0;
    ctl_o.sel   = SEL_AND;
    ctl_o.arith = 1'b0;
    ctl_o.slt   = 1'b0;
    case (code_i)
      OP_OR:  ctl_o.sel = SEL_OR;
      OP_ADD: begin
        ctl_o.sel   = SEL_SUM;
        ctl_o.arith = 1'b1;
      end
      OP_SUB: begin
        ctl_o.neg_b = 1'b1;
        ctl_o.sel   = SEL_SUM;
        ctl_o.arith = 1'b1;
      end
      OP_SLT: begin
        ctl_o.neg_b = 1'b1;
        ctl_o.sel   = SEL_LESS;
        ctl_o.slt   = 1'b1;
      end
      OP_NOR: begin
        ctl_o.inv_a = 1'b1;
        ctl_o.neg_b = 1'b1;
        ctl_o.sel   = SEL_AND;
      end
      default: ;  // OP_AND and all unlisted codes
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic carry_i,
  input  logic less_i,
  input  logic inv_a_i,
  input  logic neg_b_i,
  input  sel_e sel_i,
  output logic res_o,
  output logic sum_o,
  output logic carry_o
);

  logic a_x, b_x;

  assign a_x     = a_i ^ inv_a_i;
  assign b_x     = b_i ^ neg_b_i;
  assign sum_o   = a_x ^ b_x ^ carry_i;
  assign carry_o = (a_x & b_x) | (a_x & carry_i) | (b_x & carry_i);

  always_comb begin
    case (sel_i)
      SEL_OR:   res_o = a_x | b_x;
      SEL_SUM:  res_o = sum_o;
      SEL_LESS: res_o = less_i;
      default:  res_o = a_x & b_x;
    endcase
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] result_i,
  input  logic         msb_sum_i,
  input  logic         msb_carry_in_i,
  input  logic         msb_carry_out_i,
  input  logic         arith_i,
  input  logic         slt_i,
  output logic         less0_o,
  output logic         zero_o,
  output logic         ovf_o,
  output logic         cout_o
);

  logic ovf_raw;

  assign ovf_raw = msb_carry_in_i ^ msb_carry_out_i;
  // sign corrected for overflow feeds slice 0
  assign less0_o = msb_sum_i ^ ovf_raw;
  assign zero_o  = ~|result_i;
  assign ovf_o   = arith_i & ovf_raw;
  assign cout_o  = (arith_i | slt_i) & msb_carry_out_i;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   ctrl_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         ovf_o,
  output logic         cout_o
);

  localparam int unsigned MSB = W - 1;

  ctl_t         ctl;
  logic [W:0]   carry;
  logic [W-1:0] sum_bits;
  logic         less0;

  alu_ctrl_dec u_dec (
    .code_i(ctrl_i),
    .ctl_o (ctl)
  );

  assign carry[0] = ctl.neg_b;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = less0;
    end else begin : g_rest
      assign less_in = 1'b0;
    end
    alu_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .carry_i(carry[i]),
      .less_i (less_in),
      .inv_a_i(ctl.inv_a),
      .neg_b_i(ctl.neg_b),
      .sel_i  (ctl.sel),
      .res_o  (result_o[i]),
      .sum_o  (sum_bits[i]),
      .carry_o(carry[i+1])
    );
  end

  alu_flags #(.W(W)) u_flags (
    .result_i       (result_o),
    .msb_sum_i      (sum_bits[MSB]),
    .msb_carry_in_i (carry[MSB]),
    .msb_carry_out_i(carry[W]),
    .arith_i        (ctl.arith),
    .slt_i          (ctl.slt),
    .less0_o        (less0),
    .zero_o         (zero_o),
    .ovf_o          (ovf_o),
    .cout_o         (cout_o)
  );

  // checks against arithmetic on the ports
  logic [W-1:0] chk_a, chk_b;
  logic [W:0]   chk_sum;
  logic         chk_known;

  always_comb begin
    chk_a     = a_i ^ {W{ctl.inv_a}};
    chk_b     = b_i ^ {W{ctl.neg_b}};
    chk_sum   = {1'b0, chk_a} + {1'b0, chk_b} + {{W{1'b0}}, carry[0]};
    chk_known = !$isunknown({a_i, b_i, ctrl_i});
    if (chk_known) begin
      if (ctl.arith || ctl.slt)
        AST_CARRY_CHAIN: assert ({carry[W], sum_bits} == chk_sum) else $error("ripple chain mismatch"); // R1
      if (ctrl_i == OP_SLT)
        AST_SLT_UPPER_ZERO: assert (result_o[MSB:1] == '0) else $error("slt upper bits set"); // R6
      if (ctrl_i == OP_SLT)
        AST_SLT_SIGNED: assert (result_o[0] == ($signed(a_i) < $signed(b_i))) else $error("slt wrong"); // R6
      if (ctrl_i == OP_ADD && ovf_o)
        AST_OVF_SIGN: assert (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]) else $error("bad ovf"); // R3
      if (ctrl_i == OP_NOR)
        AST_NOR_RESULT: assert (result_o == ~(a_i | b_i)) else $error("nor wrong"); // R5
      if (!(ctrl_i inside {OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR}))
        AST_DEFAULT_AND: assert (result_o == (a_i & b_i) && !ovf_o && !cout_o) else $error("default not AND"); // R8
    end
  end

endmodule

// File: tb/slice_alu_tb.sv
module slice_alu_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [3:0]   ctrl;
  logic         zero, ovf, cout;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  slice_alu #(.W(W)) u_dut (
    .a_i(a), .b_i(b), .ctrl_i(ctrl),
    .result_o(res), .zero_o(zero), .ovf_o(ovf), .cout_o(cout)
  );

  task automatic chk_v(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_b(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // behavioural reference, applied on one clock and compared mid-cycle
  task automatic apply(input logic [3:0] op, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0]   s;
    logic [W-1:0] er;
    logic         eo, ec;
    string        t;
    eo = 1'b0;
    ec = 1'b0;
    case (op)
      4'b0010: begin
        s  = {1'b0, x} + {1'b0, y};
        er = s[W-1:0];
        ec = s[W];
        eo = (x[W-1] == y[W-1]) && (er[W-1] != x[W-1]);
        t  = "R1";
      end
      4'b0110: begin
        er = x - y;
        ec = (x >= y);
        eo = (x[W-1] != y[W-1]) && (er[W-1] != x[W-1]);
        t  = "R2";
      end
      4'b0111: begin
        er = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
        ec = (x >= y);
        t  = "R6";
      end
      4'b0000: begin er = x & y;    t = "R4"; end
      4'b0001: begin er = x | y;    t = "R4"; end
      4'b1100: begin er = ~(x | y); t = "R5"; end
      default: begin er = x & y;    t = "R8"; end
    endcase
    @(posedge clk);
    ctrl = op;
    a    = x;
    b    = y;
    @(negedge clk);
    chk_v({t, " result"}, res, er);
    chk_b((t == "R8") ? "R8 ovf" : "R3 ovf", ovf, eo);
    chk_b("R7 zero", zero, (er == '0));
    if (op inside {4'b0000, 4'b0001, 4'b1100}) chk_b("R9 cout", cout, 1'b0);
    else chk_b({t, " cout"}, cout, ec);
  endtask

  initial begin
    a = '0;
    b = '0;
    ctrl = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands, AND code
    chk_v("R4 reset result", res, '0);
    chk_b("R7 reset zero", zero, 1'b1);
    chk_b("R3 reset ovf", ovf, 1'b0);
    chk_b("R9 reset cout", cout, 1'b0);
    rst_ni = 1'b1;

    // carry runs and overflow corners
    apply(4'b0010, 32'hffff_ffff, 32'h0000_0001);  // R1 full carry, zero
    apply(4'b0010, 32'h7fff_ffff, 32'h0000_0001);  // R3 positive overflow
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000);  // R3 negative overflow
    apply(4'b0110, 32'h8000_0000, 32'h0000_0001);  // R2 R3 sub overflow
    apply(4'b0110, 32'h1234_5678, 32'h1234_5678);  // R7 equality
    apply(4'b0110, 32'h0000_0000, 32'h0000_0001);  // R2 borrow
    apply(4'b0111, 32'h8000_0000, 32'h0000_0001);  // R6 negative < positive
    apply(4'b0111, 32'h7fff_ffff, 32'hffff_ffff);  // R6 false
    apply(4'b0111, 32'h8000_0000, 32'h7fff_ffff);  // R6 with overflow -> 1
    apply(4'b0111, 32'h7fff_ffff, 32'h8000_0000);  // R6 with overflow -> 0
    apply(4'b0111, 32'h0000_0005, 32'h0000_0005);  // R6 equal
    apply(4'b1100, 32'h0000_0000, 32'h0000_0000);  // R5 all ones
    apply(4'b1100, 32'hffff_0000, 32'h0000_ffff);  // R5 zero
    apply(4'b0001, 32'h0f0f_0f0f, 32'hf0f0_f0f0);  // R4
    apply(4'b0000, 32'hffff_ffff, 32'ha5a5_5a5a);  // R4
    apply(4'b0011, 32'hffff_ffff, 32'h0000_0001);  // R8
    apply(4'b1111, 32'hffff_ffff, 32'hffff_ffff);  // R8

    // all codes against random operands
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] x, y;
      x = $urandom();
      y = (n % 4 == 0) ? x : $urandom();
      for (int c = 0; c < 16; c++) apply(c[3:0], x, y);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule